// File: doc/BRIEF.md
# Dual-Window Bank Address Expander

This block widens a 16-bit CPU address with six extra high-order lines, giving access to a 512 KB space through two bank windows placed in the CPU map. Software picks the bank seen through each window by writing a bank number into one of two small registers on a byte-wide register bus. The next CPU access that lands in that window then drives the stored bank onto the extended lines.

Each CPU address is decoded in the same cycle. On-chip regions (registers, RAM, non-volatile memory), given as inclusive base and limit pairs, override both windows, so those regions look the same whatever bank is selected. Where the two windows overlap, the first window wins and the overlapped part of the second cannot be reached. The block reports which window, if any, is serving the access, and whether the address hit an on-chip region. The thirteen low CPU address bits pass straight through.

Top module: `bank_window_expander`

## Requirements
- R1: The first bank register answers at register offset 0x58 and the second at 0x59; writes to any other offset change neither register, and reads of any other offset return 0x00.
- R2: Bits 6 down to 1 of a bank register hold the bank; bit 6 drives ext_hi[5] (address line 18) and bit 1 drives ext_hi[0] (address line 13).
- R3: Bits 7 and 0 of each bank register ignore writes and always read back as 0.
- R4: After reset both bank registers read 0x00, and a register holds its value in every cycle without a write to its offset.
- R5: An address inside window 1 and outside every on-chip region raises win1_act, lowers win2_act and drives the first bank register's bank onto ext_hi.
- R6: An address inside window 2, outside window 1 and outside every on-chip region raises win2_act, lowers win1_act and drives the second bank onto ext_hi.
- R7: An address inside both windows is served by window 1; win2_act stays low.
- R8: An address inside any on-chip region raises onchip_hit, keeps both window flags low and drives ext_hi to zero, whatever either bank register holds.
- R9: An address in no window and no on-chip region drives ext_hi to zero with both window flags and onchip_hit low.
- R10: addr_lo always equals CPU address bits 12:0.
- R11: Region and window bounds are inclusive at both ends, decode is combinational on the current address, and a bank write changes ext_hi only from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cpu_addr | input | 16 | CPU address of the current access |
| addr_lo | output | 13 | CPU address bits 12:0, passed through |
| ext_hi | output | 6 | Extended address lines 18 down to 13 |
| win1_act | output | 1 | Window 1 serves the access |
| win2_act | output | 1 | Window 2 serves the access |
| onchip_hit | output | 1 | Address lies in an on-chip region |

## Verification
The bench builds the block with window 1 at 0x4000 to 0x7FFF and window 2 at 0x6000 to 0x9FFF, so the two overlap over 0x6000 to 0x7FFF. On-chip regions sit at 0x0000 to 0x007F, at 0x4000 to 0x43FF inside window 1, and at 0x9E00 to 0x9FFF inside the part of window 2 only it reaches. This places every precedence case, each inclusive boundary on both sides, and the unmapped space above 0xA000 within reach of directed addresses.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    localparam int unsigned BANK_W = 6;
    localparam int unsigned CPU_AW = 16;
    localparam int unsigned LOW_W  = 13;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ONCHIP = 2'd1,
        SRC_WIN1   = 2'd2,
        SRC_WIN2   = 2'd3
    } src_e;

    typedef struct packed {
        bank_t sel1;
        bank_t sel2;
    } bank_state_t;

endpackage

// File: rtl/bwx_range_hit.sv
module bwx_range_hit #(
    parameter int unsigned        AW = 16,
    parameter logic [AW-1:0]      LO = '0,
    parameter logic [AW-1:0]      HI = '1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);

    always_comb begin
        hit = (addr >= LO) && (addr <= HI);
    end

endmodule

// File: rtl/bwx_bank_regs.sv
module bwx_bank_regs
    import bwx_pkg::*;
#(
    parameter int unsigned       RAW  = 8,
    parameter int unsigned       DW   = 8,
    parameter logic [RAW-1:0]    OFS1 = 8'h58,
    parameter logic [RAW-1:0]    OFS2 = 8'h59
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output bank_t          bank1,
    output bank_t          bank2
);

    localparam int unsigned FIELD_LO = 1;
    localparam int unsigned FIELD_HI = FIELD_LO + BANK_W - 1;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (reg_we && (reg_addr == OFS1)) begin
            state_d.sel1 = reg_wdata[FIELD_HI:FIELD_LO];
        end
        if (reg_we && (reg_addr == OFS2)) begin
            state_d.sel2 = reg_wdata[FIELD_HI:FIELD_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS1) begin
            reg_rdata[FIELD_HI:FIELD_LO] = state_q.sel1;
        end else if (reg_addr == OFS2) begin
            reg_rdata[FIELD_HI:FIELD_LO] = state_q.sel2;
        end
    end

    assign bank1 = state_q.sel1;
    assign bank2 = state_q.sel2;

    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DW-1] == 1'b0) && (reg_rdata[0] == 1'b0)); // R3

    AST_WRITE_LANDS1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS1) |=> (bank1 == $past(reg_wdata[FIELD_HI:FIELD_LO]))); // R2

    AST_HOLD_NO_WRITE1: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFS1) |=> $stable(bank1)); // R4

    AST_HOLD_NO_WRITE2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFS2) |=> $stable(bank2)); // R4

endmodule

// File: rtl/bwx_decode.sv
module bwx_decode
    import bwx_pkg::*;
#(
    parameter logic [CPU_AW-1:0]          W1_BASE = 16'h4000,
    parameter logic [CPU_AW-1:0]          W1_SIZE = 16'h4000,
    parameter logic [CPU_AW-1:0]          W2_BASE = 16'h6000,
    parameter logic [CPU_AW-1:0]          W2_SIZE = 16'h4000,
    parameter int unsigned                N_OC    = 3,
    parameter logic [N_OC*CPU_AW-1:0]     OC_BASE = {16'h9E00, 16'h4000, 16'h0000},
    parameter logic [N_OC*CPU_AW-1:0]     OC_LIM  = {16'h9FFF, 16'h43FF, 16'h007F}
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  bank_t             bank1,
    input  bank_t             bank2,
    output bank_t             ext_hi,
    output src_e              src
);

    localparam logic [CPU_AW:0] W1_END = {1'b0, W1_BASE} + {1'b0, W1_SIZE} - 1'b1;
    localparam logic [CPU_AW:0] W2_END = {1'b0, W2_BASE} + {1'b0, W2_SIZE} - 1'b1;

    logic            w1_hit, w2_hit;
    logic [N_OC-1:0] oc_hit;

    bwx_range_hit #(.AW(CPU_AW), .LO(W1_BASE), .HI(W1_END[CPU_AW-1:0])) u_win1 (
        .addr (cpu_addr),
        .hit  (w1_hit)
    );

    bwx_range_hit #(.AW(CPU_AW), .LO(W2_BASE), .HI(W2_END[CPU_AW-1:0])) u_win2 (
        .addr (cpu_addr),
        .hit  (w2_hit)
    );

    for (genvar g = 0; g < N_OC; g++) begin : g_oc
        bwx_range_hit #(
            .AW (CPU_AW),
            .LO (OC_BASE[g*CPU_AW +: CPU_AW]),
            .HI (OC_LIM[g*CPU_AW +: CPU_AW])
        ) u_oc (
            .addr (cpu_addr),
            .hit  (oc_hit[g])
        );
    end

    always_comb begin
        if (|oc_hit) begin
            src = SRC_ONCHIP;
        end else if (w1_hit) begin
            src = SRC_WIN1;
        end else if (w2_hit) begin
            src = SRC_WIN2;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_WIN1: ext_hi = bank1;
            SRC_WIN2: ext_hi = bank2;
            default:  ext_hi = '0;
        endcase
    end

endmodule

// File: rtl/bank_window_expander.sv
module bank_window_expander
    import bwx_pkg::*;
#(
    parameter logic [15:0]  W1_BASE = 16'h8000,
    parameter logic [15:0]  W1_SIZE = 16'h2000,
    parameter logic [15:0]  W2_BASE = 16'hA000,
    parameter logic [15:0]  W2_SIZE = 16'h4000,
    parameter int unsigned  N_OC    = 3,
    parameter logic [N_OC*16-1:0] OC_BASE = {16'hFE00, 16'h0080, 16'h0000},
    parameter logic [N_OC*16-1:0] OC_LIM  = {16'hFFFF, 16'h047F, 16'h007F},
    parameter logic [7:0]   OFS1    = 8'h58,
    parameter logic [7:0]   OFS2    = 8'h59
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] cpu_addr,
    output logic [12:0] addr_lo,
    output logic [5:0]  ext_hi,
    output logic        win1_act,
    output logic        win2_act,
    output logic        onchip_hit
);

    bank_t bank1, bank2, hi_sel;
    src_e  src;

    bwx_bank_regs #(.RAW(8), .DW(8), .OFS1(OFS1), .OFS2(OFS2)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bank1     (bank1),
        .bank2     (bank2)
    );

    bwx_decode #(
        .W1_BASE (W1_BASE), .W1_SIZE (W1_SIZE),
        .W2_BASE (W2_BASE), .W2_SIZE (W2_SIZE),
        .N_OC    (N_OC),
        .OC_BASE (OC_BASE), .OC_LIM (OC_LIM)
    ) u_dec (
        .cpu_addr (cpu_addr),
        .bank1    (bank1),
        .bank2    (bank2),
        .ext_hi   (hi_sel),
        .src      (src)
    );

    assign addr_lo    = cpu_addr[LOW_W-1:0];
    assign ext_hi     = hi_sel;
    assign win1_act   = (src == SRC_WIN1);
    assign win2_act   = (src == SRC_WIN2);
    assign onchip_hit = (src == SRC_ONCHIP);

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({win1_act, win2_act, onchip_hit}) <= 1); // R7

    AST_ONCHIP_HIDES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        onchip_hit |-> (ext_hi == '0)); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(win1_act || win2_act) |-> (ext_hi == '0)); // R9

    AST_WIN1_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        win1_act |-> (ext_hi == reg_rdata_bank1())); // R5

    function automatic bank_t reg_rdata_bank1();
        return bank1;
    endfunction

endmodule

// File: tb/test_bank_window_expander.sv
module test_bank_window_expander;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr;
    logic [12:0] addr_lo;
    logic [5:0]  ext_hi;
    logic        win1_act, win2_act, onchip_hit;

    int checks = 0;
    int errors = 0;
    logic [5:0] m_b1 = '0;
    logic [5:0] m_b2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_window_expander #(
        .W1_BASE (16'h4000), .W1_SIZE (16'h4000),
        .W2_BASE (16'h6000), .W2_SIZE (16'h4000),
        .N_OC    (3),
        .OC_BASE ({16'h9E00, 16'h4000, 16'h0000}),
        .OC_LIM  ({16'h9FFF, 16'h43FF, 16'h007F}),
        .OFS1    (8'h58), .OFS2 (8'h59)
    ) i_bank_window_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cpu_addr   (cpu_addr),
        .addr_lo    (addr_lo),
        .ext_hi     (ext_hi),
        .win1_act   (win1_act),
        .win2_act   (win2_act),
        .onchip_hit (onchip_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 8'h58) m_b1 = d[6:1];
        if (a == 8'h59) m_b2 = d[6:1];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    // expected decode: {onchip, win1, win2, ext_hi}
    function automatic logic [8:0] model(input logic [15:0] a);
        logic oc;
        oc = (a <= 16'h007F) || (a >= 16'h4000 && a <= 16'h43FF) ||
             (a >= 16'h9E00 && a <= 16'h9FFF);
        if (oc) return {3'b100, 6'd0};
        if (a >= 16'h4000 && a <= 16'h7FFF) return {3'b010, m_b1};
        if (a >= 16'h6000 && a <= 16'h9FFF) return {3'b001, m_b2};
        return 9'd0;
    endfunction

    task automatic probe(input string req, input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, {23'd0, onchip_hit, win1_act, win2_act, ext_hi}, {23'd0, model(a)});
        chk({req, "/R10"}, {19'd0, addr_lo}, {19'd0, a[12:0]});
    endtask

    task automatic t_reset();
        rd("R4 reset bank1", 8'h58, 8'h00);
        rd("R4 reset bank2", 8'h59, 8'h00);
        probe("R4 reset window1 zero", 16'h5000);
    endtask

    task automatic t_regs();
        wr(8'h58, 8'hFF);
        rd("R3 bank1 rsvd bits", 8'h58, 8'h7E);
        wr(8'h59, 8'h81);
        rd("R3 bank2 rsvd bits", 8'h59, 8'h00);
        wr(8'h59, 8'h2A);
        rd("R1 bank2 write", 8'h59, 8'h2A);
        wr(8'h5A, 8'h54);
        wr(8'h57, 8'h54);
        rd("R1 other offset write ignored b1", 8'h58, 8'h7E);
        rd("R1 other offset write ignored b2", 8'h59, 8'h2A);
        rd("R1 other offset reads zero", 8'h5A, 8'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
        end
        rd("R4 bank1 holds", 8'h58, 8'h7E);
    endtask

    task automatic t_bitmap();
        wr(8'h58, 8'h40);
        probe("R2 bit6 to line18", 16'h5000);
        chk("R2 ext_hi[5]", {31'd0, ext_hi[5]}, 32'd1);
        wr(8'h58, 8'h02);
        probe("R2 bit1 to line13", 16'h5000);
        chk("R2 ext_hi[0]", {26'd0, ext_hi}, 32'd1);
    endtask

    task automatic t_windows();
        wr(8'h58, 8'h16);
        wr(8'h59, 8'h6C);
        probe("R5 window1 only", 16'h5ABC);
        probe("R5 window1 low edge past oc", 16'h4400);
        probe("R6 window2 only", 16'h8123);
        probe("R6 window2 edge", 16'h8000);
        probe("R7 overlap low", 16'h6000);
        probe("R7 overlap mid", 16'h7123);
        probe("R7 overlap high", 16'h7FFF);
    endtask

    task automatic t_onchip();
        probe("R8 regs low", 16'h0000);
        probe("R8 regs high", 16'h007F);
        probe("R8 ram in window1", 16'h4000);
        probe("R8 ram end", 16'h43FF);
        probe("R8 rom in window2", 16'h9E00);
        probe("R8 rom end", 16'h9FFF);
        wr(8'h58, 8'h7E);
        probe("R8 bank independent", 16'h4100);
    endtask

    task automatic t_nohit();
        probe("R9 just above regs", 16'h0080);
        probe("R9 below window1", 16'h3FFF);
        probe("R9 above window2", 16'hA000);
        probe("R9 top", 16'hFFFF);
        probe("R11 window2 last before oc", 16'h9DFF);
    endtask

    task automatic t_timing();
        @(negedge clk);
        cpu_addr = 16'h5555;
        reg_we = 1'b1; reg_addr = 8'h58; reg_wdata = 8'h0A;
        #1;
        chk("R11 before edge old bank", {26'd0, ext_hi}, {26'd0, m_b1});
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        m_b1 = 6'h05;
        chk("R11 after edge new bank", {26'd0, ext_hi}, 32'h05);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; cpu_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_bitmap();
        t_windows();
        t_onchip();
        t_nohit();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule